// File: doc/BRIEF.md
# Labeled Frame Transit Classifier

This block sits in the transit path of an encapsulating switch and watches the inner header of each frame as it arrives, one byte per accepted cycle. It counts bytes from the first byte of the inner destination MAC address. It reads the type value that follows the two inner MAC addresses and decides whether the frame carries a plain VLAN tag, a 24-bit fine-grained label, or something it must refuse.

From the first tag or label word it takes the transport priority and drop-eligible bit, which feed queue selection. It also assembles the full label. For multi-destination frames it returns a per-branch forward mask. On labeled frames that mask is built from an interest lookup that the surrounding logic answers in the same cycle. Frames that arrived as unicast but name a group or unknown inner destination are marked for local delivery only and are never forwarded.

Top module: `lbl_transit_classifier`

## Requirements
- R1: Byte index 0 is the byte presented with `in_start`; only cycles with `in_vld` high advance the index. The type at bytes 12..13 (byte 12 high) selects the format, reported on `res_fmt` as 1 = VLAN for 0x8100 and 2 = LABEL for 0x893B.
- R2: Priority is bits 7:5 and the drop-eligible bit is bit 4 of byte 14, for both the VLAN and the LABEL format.
- R3: For LABEL the 24-bit label is {byte14[3:0], byte15, byte18[3:0], byte19}. For VLAN it is the 12-bit VLAN ID {byte14[3:0], byte15} zero-extended.
- R4: `res_vld` is a one-cycle pulse in the cycle after the deciding byte. The deciding byte is byte 13 for a refused type, byte 15 for VLAN, byte 17 for a bad second label type, and byte 19 for LABEL.
- R5: Any other type at bytes 12..13, or a LABEL frame whose bytes 16..17 are not 0x893B, gives `res_fmt` = 3, `res_drop` = 1, a zero forward mask, no local delivery, and zero priority, drop-eligible bit and label.
- R6: On the cycle byte 19 of a LABEL frame is accepted, `lkup_req` is high with the lookup key on `lkup_key`. For a LABEL frame with `hdr_mdest` = 1, `res_fwd` bit b equals `lkup_hit` bit b of that cycle.
- R7: Parameter PRUNE_KEY selects the lookup key: 0 the full label; 1 the high 12 bits with the low half zero; 2 the low 12 bits with the high half zero.
- R8: A VLAN frame with `hdr_mdest` = 1 is forwarded on every branch.
- R9: With `hdr_mdest` = 0 the forward mask is zero. `res_local_only` is 1 when the frame is not dropped and either bit 0 of byte 0 is set (group destination) or `da_unknown` was high with byte 0.
- R10: With parameter LABEL_EN = 0, type 0x893B is refused as in R5, with the decision made at byte 13.
- R11: After reset, `res_vld`, `res_fmt`, `res_label` and `res_fwd` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Byte on `in_byte` is valid this cycle |
| in_start | input | 1 | Marks byte 0 of a new inner header |
| in_byte | input | 8 | Inner header byte |
| hdr_mdest | input | 1 | Multi-destination bit of the outer header, sampled with byte 0 |
| da_unknown | input | 1 | Inner destination not known, sampled with byte 0 |
| lkup_req | output | 1 | Interest lookup is being asked this cycle |
| lkup_key | output | 24 | Label key for the interest lookup |
| lkup_hit | input | BRANCHES | Per-branch interest answer for `lkup_key`, same cycle |
| res_vld | output | 1 | Result pulse |
| res_fmt | output | 2 | 1 VLAN, 2 LABEL, 3 refused |
| res_pri | output | 3 | Transport priority |
| res_dei | output | 1 | Drop-eligible bit |
| res_label | output | 24 | Extracted label or VLAN ID |
| res_fwd | output | BRANCHES | Per-branch forward mask |
| res_drop | output | 1 | Frame refused and discarded |
| res_local_only | output | 1 | Local delivery allowed, no forwarding |

## Verification
The assertions assume that `in_start` is only raised together with `in_vld`, and that a new header starts no sooner than 14 accepted bytes after the previous one. They also assume that `lkup_hit` answers in the same cycle as `lkup_req`. The bench keeps within these limits. It feeds whole 22-byte headers, sometimes with idle cycles between bytes, and drives `lkup_hit` as a combinational function of the key the design presents. The sweep covers every format case, both destination-bit values, group and unknown destinations, and all priority values.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
   typedef enum logic [1:0] {
      FMT_NONE  = 2'd0,
      FMT_VLAN  = 2'd1,
      FMT_LABEL = 2'd2,
      FMT_BAD   = 2'd3
   } lbl_fmt_e;

   localparam int MAC_BYTES = 6;
   localparam int HALF_W    = 12;
   localparam int LBL_W     = 2 * HALF_W;

   localparam logic [15:0] TYPE_VLAN  = 16'h8100;
   localparam logic [15:0] TYPE_LABEL = 16'h893B;

   localparam int OFS_T1_HI = 2 * MAC_BYTES;
   localparam int OFS_T1_LO = OFS_T1_HI + 1;
   localparam int OFS_W1_HI = OFS_T1_HI + 2;
   localparam int OFS_W1_LO = OFS_T1_HI + 3;
   localparam int OFS_T2_HI = OFS_T1_HI + 4;
   localparam int OFS_T2_LO = OFS_T1_HI + 5;
   localparam int OFS_W2_HI = OFS_T1_HI + 6;
   localparam int OFS_W2_LO = OFS_T1_HI + 7;
endpackage

// File: rtl/lbl_byte_index.sv
module lbl_byte_index #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic             in_start,
   input  logic             frame_done,
   output logic             cur_act,
   output logic [IDX_W-1:0] cur_idx
);
   logic             act_q;
   logic [IDX_W-1:0] cnt_q;

   assign cur_act = in_vld & (in_start | act_q);
   assign cur_idx = in_start ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (cur_act) begin
         if (frame_done) begin
            act_q <= 1'b0;
         end else begin
            act_q <= 1'b1;
            cnt_q <= cur_idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lbl_key_select.sv
module lbl_key_select #(
   parameter int PRUNE_KEY = 0,
   parameter int HALF_W    = 12
) (
   input  logic [2*HALF_W-1:0] full_lbl,
   output logic [2*HALF_W-1:0] key
);
   generate
      if (PRUNE_KEY == 0) begin : g_full
         assign key = full_lbl;
      end else if (PRUNE_KEY == 1) begin : g_high
         assign key = {full_lbl[2*HALF_W-1:HALF_W], {HALF_W{1'b0}}};
      end else if (PRUNE_KEY == 2) begin : g_low
         assign key = {{HALF_W{1'b0}}, full_lbl[HALF_W-1:0]};
      end else begin : g_bad
         $error("PRUNE_KEY must be 0, 1 or 2");
         assign key = full_lbl;
      end
   endgenerate
endmodule

// File: rtl/lbl_fwd_decide.sv
module lbl_fwd_decide
   import lbl_pkg::*;
#(
   parameter int BRANCHES = 4
) (
   input  lbl_fmt_e            fmt,
   input  logic                mdest,
   input  logic                grp_da,
   input  logic                unk_da,
   input  logic [BRANCHES-1:0] hit,
   output logic [BRANCHES-1:0] fwd,
   output logic                local_only
);
   always_comb begin
      fwd        = '0;
      local_only = 1'b0;
      if (fmt != FMT_BAD) begin
         if (mdest) begin
            fwd = (fmt == FMT_LABEL) ? hit : {BRANCHES{1'b1}};
         end else begin
            local_only = grp_da | unk_da;
         end
      end
   end
endmodule

// File: rtl/lbl_transit_classifier.sv
module lbl_transit_classifier
   import lbl_pkg::*;
#(
   parameter int BRANCHES  = 4,
   parameter int PRUNE_KEY = 0,
   parameter bit LABEL_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic                in_start,
   input  logic [7:0]          in_byte,
   input  logic                hdr_mdest,
   input  logic                da_unknown,
   output logic                lkup_req,
   output logic [23:0]         lkup_key,
   input  logic [BRANCHES-1:0] lkup_hit,
   output logic                res_vld,
   output logic [1:0]          res_fmt,
   output logic [2:0]          res_pri,
   output logic                res_dei,
   output logic [23:0]         res_label,
   output logic [BRANCHES-1:0] res_fwd,
   output logic                res_drop,
   output logic                res_local_only
);
   localparam int IDX_W = $clog2(OFS_W2_LO + 1);
   localparam logic [IDX_W-1:0] I_DA0  = '0;
   localparam logic [IDX_W-1:0] I_T1HI = IDX_W'(OFS_T1_HI);
   localparam logic [IDX_W-1:0] I_T1LO = IDX_W'(OFS_T1_LO);
   localparam logic [IDX_W-1:0] I_W1HI = IDX_W'(OFS_W1_HI);
   localparam logic [IDX_W-1:0] I_W1LO = IDX_W'(OFS_W1_LO);
   localparam logic [IDX_W-1:0] I_T2HI = IDX_W'(OFS_T2_HI);
   localparam logic [IDX_W-1:0] I_T2LO = IDX_W'(OFS_T2_LO);
   localparam logic [IDX_W-1:0] I_W2HI = IDX_W'(OFS_W2_HI);
   localparam logic [IDX_W-1:0] I_W2LO = IDX_W'(OFS_W2_LO);

   generate
      if (BRANCHES < 1 || BRANCHES > 64) begin : g_chk_br
         $error("BRANCHES must lie in 1..64");
      end
      if (LBL_W != 24) begin : g_chk_lbl
         $error("label width must be 24");
      end
   endgenerate

   logic             cur_act;
   logic [IDX_W-1:0] cur_idx;
   logic             fin_bad, fin_vlan, fin_label, fin_any;
   logic             lbl_accept;
   logic [15:0]      typ_now;
   lbl_fmt_e         fmt_q, fmt_fin;
   logic [7:0]       typ_hi_q, w1_hi_q, w1_lo_q;
   logic [3:0]       w2_hi_q;
   logic             grp_q, mdest_q, unk_q;
   logic [23:0]      full_lbl;
   logic [BRANCHES-1:0] fwd_next;
   logic             local_next;

   assign typ_now  = {typ_hi_q, in_byte};
   assign full_lbl = {w1_hi_q[3:0], w1_lo_q, w2_hi_q, in_byte};

   generate
      if (LABEL_EN) begin : g_lbl_on
         assign lbl_accept = (typ_now == TYPE_LABEL);
      end else begin : g_lbl_off
         assign lbl_accept = 1'b0;
      end
   endgenerate

   lbl_byte_index #(.IDX_W(IDX_W)) u_idx (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_vld     (in_vld),
      .in_start   (in_start),
      .frame_done (fin_any),
      .cur_act    (cur_act),
      .cur_idx    (cur_idx)
   );

   always_comb begin
      fin_bad   = 1'b0;
      fin_vlan  = 1'b0;
      fin_label = 1'b0;
      if (cur_act) begin
         if (cur_idx == I_T1LO) begin
            fin_bad = !((typ_now == TYPE_VLAN) || lbl_accept);
         end else if (cur_idx == I_W1LO) begin
            fin_vlan = (fmt_q == FMT_VLAN);
         end else if (cur_idx == I_T2LO) begin
            fin_bad = (typ_now != TYPE_LABEL);
         end else if (cur_idx == I_W2LO) begin
            fin_label = (fmt_q == FMT_LABEL);
         end
      end
      fin_any = fin_bad | fin_vlan | fin_label;
      fmt_fin = fin_bad ? FMT_BAD : (fin_vlan ? FMT_VLAN : FMT_LABEL);
   end

   assign lkup_req = fin_label;

   lbl_key_select #(.PRUNE_KEY(PRUNE_KEY), .HALF_W(HALF_W)) u_key (
      .full_lbl (full_lbl),
      .key      (lkup_key)
   );

   lbl_fwd_decide #(.BRANCHES(BRANCHES)) u_dec (
      .fmt        (fmt_fin),
      .mdest      (mdest_q),
      .grp_da     (grp_q),
      .unk_da     (unk_q),
      .hit        (lkup_hit),
      .fwd        (fwd_next),
      .local_only (local_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q          <= FMT_NONE;
         typ_hi_q       <= '0;
         w1_hi_q        <= '0;
         w1_lo_q        <= '0;
         w2_hi_q        <= '0;
         grp_q          <= 1'b0;
         mdest_q        <= 1'b0;
         unk_q          <= 1'b0;
         res_vld        <= 1'b0;
         res_fmt        <= FMT_NONE;
         res_pri        <= '0;
         res_dei        <= 1'b0;
         res_label      <= '0;
         res_fwd        <= '0;
         res_drop       <= 1'b0;
         res_local_only <= 1'b0;
      end else begin
         res_vld <= fin_any;
         if (cur_act) begin
            if (cur_idx == I_DA0) begin
               grp_q   <= in_byte[0];
               mdest_q <= hdr_mdest;
               unk_q   <= da_unknown;
               fmt_q   <= FMT_NONE;
            end
            if (cur_idx == I_T1HI || cur_idx == I_T2HI) typ_hi_q <= in_byte;
            if (cur_idx == I_T1LO)
               fmt_q <= (typ_now == TYPE_VLAN) ? FMT_VLAN :
                        (lbl_accept ? FMT_LABEL : FMT_BAD);
            if (cur_idx == I_W1HI) w1_hi_q <= in_byte;
            if (cur_idx == I_W1LO) w1_lo_q <= in_byte;
            if (cur_idx == I_W2HI) w2_hi_q <= in_byte[3:0];
         end
         if (fin_any) begin
            res_fmt        <= fmt_fin;
            res_pri        <= fin_bad ? 3'd0 : w1_hi_q[7:5];
            res_dei        <= fin_bad ? 1'b0 : w1_hi_q[4];
            res_label      <= fin_bad  ? 24'd0 :
                              fin_vlan ? {12'd0, w1_hi_q[3:0], in_byte} : full_lbl;
            res_fwd        <= fwd_next;
            res_drop       <= fin_bad;
            res_local_only <= local_next;
         end
      end
   end
endmodule

// File: rtl/lbl_transit_classifier_chk.sv
module lbl_transit_classifier_chk #(
   parameter int BRANCHES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                lkup_req,
   input logic [BRANCHES-1:0] lkup_hit,
   input logic                res_vld,
   input logic [1:0]          res_fmt,
   input logic [23:0]         res_label,
   input logic [BRANCHES-1:0] res_fwd,
   input logic                res_drop,
   input logic                res_local_only
);
   assert_fmt_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> res_fmt != 2'd0);

   assert_vlan_id_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && res_fmt == 2'd1) |-> res_label[23:12] == 12'd0);

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> !res_vld);

   assert_bad_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && res_fmt == 2'd3) |-> (res_drop && res_fwd == '0 && !res_local_only));

   assert_req_then_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lkup_req |=> (res_vld && res_fmt == 2'd2));

   assert_fwd_within_interest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && res_fmt == 2'd2) |-> (res_fwd & ~$past(lkup_hit)) == '0);

   assert_local_not_forwarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && res_local_only) |-> res_fwd == '0);
endmodule

bind lbl_transit_classifier lbl_transit_classifier_chk #(.BRANCHES(BRANCHES)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .lkup_req       (lkup_req),
   .lkup_hit       (lkup_hit),
   .res_vld        (res_vld),
   .res_fmt        (res_fmt),
   .res_label      (res_label),
   .res_fwd        (res_fwd),
   .res_drop       (res_drop),
   .res_local_only (res_local_only)
);

// File: tb/lbl_transit_classifier_test.sv
`timescale 1ns/1ps
module lbl_transit_classifier_test;
   localparam int NB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 1'b0, in_start = 1'b0, hdr_mdest = 1'b0, da_unknown = 1'b0;
   logic [7:0] in_byte = '0;
   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [NB-1:0] interest(input logic [23:0] k);
      logic [NB-1:0] h;
      for (int b = 0; b < NB; b++)
         h[b] = (((32'(k[23:12] ^ k[11:0])) + b) % 3) == 0;
      return h;
   endfunction

   logic            a_req, b_req, c_req;
   logic [23:0]     a_key, b_key, c_key;
   logic [NB-1:0]   a_hit, b_hit, c_hit;
   logic            a_vld, b_vld, c_vld;
   logic [1:0]      a_fmt, b_fmt, c_fmt;
   logic [2:0]      a_pri, b_pri, c_pri;
   logic            a_dei, b_dei, c_dei;
   logic [23:0]     a_lbl, b_lbl, c_lbl;
   logic [NB-1:0]   a_fwd, b_fwd, c_fwd;
   logic            a_drp, b_drp, c_drp;
   logic            a_loc, b_loc, c_loc;

   assign a_hit = interest(a_key);
   assign b_hit = interest(b_key);
   assign c_hit = interest(c_key);

   lbl_transit_classifier #(.BRANCHES(NB)) uut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_start(in_start), .in_byte(in_byte),
      .hdr_mdest(hdr_mdest), .da_unknown(da_unknown), .lkup_req(a_req), .lkup_key(a_key),
      .lkup_hit(a_hit), .res_vld(a_vld), .res_fmt(a_fmt), .res_pri(a_pri), .res_dei(a_dei),
      .res_label(a_lbl), .res_fwd(a_fwd), .res_drop(a_drp), .res_local_only(a_loc));

   lbl_transit_classifier #(.BRANCHES(NB), .LABEL_EN(1'b0)) uut_vl (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_start(in_start), .in_byte(in_byte),
      .hdr_mdest(hdr_mdest), .da_unknown(da_unknown), .lkup_req(b_req), .lkup_key(b_key),
      .lkup_hit(b_hit), .res_vld(b_vld), .res_fmt(b_fmt), .res_pri(b_pri), .res_dei(b_dei),
      .res_label(b_lbl), .res_fwd(b_fwd), .res_drop(b_drp), .res_local_only(b_loc));

   lbl_transit_classifier #(.BRANCHES(NB), .PRUNE_KEY(1)) uut_hi (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_start(in_start), .in_byte(in_byte),
      .hdr_mdest(hdr_mdest), .da_unknown(da_unknown), .lkup_req(c_req), .lkup_key(c_key),
      .lkup_hit(c_hit), .res_vld(c_vld), .res_fmt(c_fmt), .res_pri(c_pri), .res_dei(c_dei),
      .res_label(c_lbl), .res_fwd(c_fwd), .res_drop(c_drp), .res_local_only(c_loc));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   int sent, a_n, a_at, b_n, b_at, ka_n, kc_n;
   logic [1:0] ra_fmt, rb_fmt;
   logic [2:0] ra_pri;
   logic ra_dei, ra_drp, ra_loc, rb_drp;
   logic [23:0] ra_lbl, ka_key, kc_key;
   logic [NB-1:0] ra_fwd;

   task automatic sample_res();
      if (a_vld) begin
         a_n++; a_at = sent;
         ra_fmt = a_fmt; ra_pri = a_pri; ra_dei = a_dei; ra_lbl = a_lbl;
         ra_fwd = a_fwd; ra_drp = a_drp; ra_loc = a_loc;
      end
      if (b_vld) begin
         b_n++; b_at = sent; rb_fmt = b_fmt; rb_drp = b_drp;
      end
   endtask

   // kind: 0 VLAN, 1 LABEL, 2 refused first type, 3 bad second type
   task automatic run_frame(input int kind, input logic m, input logic grp, input logic unk,
                            input logic [2:0] pri, input logic dei, input logic [11:0] hi,
                            input logic [11:0] lo, input logic [15:0] bad_t, input bit gap);
      logic [7:0] fb [0:21];
      int exp_at, exp_vl_at;
      logic [1:0] exp_fmt;
      logic [23:0] exp_lbl;
      logic [NB-1:0] exp_fwd;
      logic exp_loc;
      for (int i = 0; i < 22; i++) fb[i] = 8'(i * 13 + 32'(hi));
      fb[0] = {fb[0][7:1], grp};
      fb[12] = (kind == 0) ? 8'h81 : (kind == 2) ? bad_t[15:8] : 8'h89;
      fb[13] = (kind == 0) ? 8'h00 : (kind == 2) ? bad_t[7:0]  : 8'h3B;
      fb[14] = {pri, dei, hi[11:8]};
      fb[15] = hi[7:0];
      fb[16] = (kind == 3) ? 8'h81 : 8'h89;
      fb[17] = (kind == 3) ? 8'h00 : 8'h3B;
      fb[18] = {~pri, ~dei, lo[11:8]};
      fb[19] = lo[7:0];
      sent = 0; a_n = 0; b_n = 0; ka_n = 0; kc_n = 0; a_at = -1; b_at = -1;
      for (int i = 0; i < 22; i++) begin
         @(negedge clk);
         sample_res();
         in_vld = 1'b1; in_start = (i == 0); in_byte = fb[i];
         hdr_mdest = m; da_unknown = unk;
         #1;
         if (a_req) begin ka_n++; ka_key = a_key; end
         if (c_req) begin kc_n++; kc_key = c_key; end
         sent++;
         if (gap) begin
            @(negedge clk);
            sample_res();
            in_vld = 1'b0; in_start = 1'b0;
         end
      end
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         sample_res();
         in_vld = 1'b0; in_start = 1'b0;
      end
      exp_at    = (kind == 0) ? 16 : (kind == 1) ? 20 : (kind == 2) ? 14 : 18;
      exp_vl_at = (kind == 0) ? 16 : 14;
      exp_fmt   = (kind == 0) ? 2'd1 : (kind == 1) ? 2'd2 : 2'd3;
      exp_lbl   = (kind == 0) ? {12'd0, hi} : (kind == 1) ? {hi, lo} : 24'd0;
      exp_fwd   = '0;
      if (m && kind == 0) exp_fwd = '1;
      if (m && kind == 1) exp_fwd = interest({hi, lo});
      exp_loc   = !m && (grp || unk) && (kind < 2);
      chk("R4 result count", 32'(a_n), 1);
      chk("R4 result timing", 32'(a_at), 32'(exp_at));
      chk("R1/R5 format", 32'(ra_fmt), 32'(exp_fmt));
      chk("R2 priority", 32'(ra_pri), (kind < 2) ? 32'(pri) : 0);
      chk("R2 dei", 32'(ra_dei), (kind < 2) ? 32'(dei) : 0);
      chk("R3 label", 32'(ra_lbl), 32'(exp_lbl));
      chk("R6/R8 forward mask", 32'(ra_fwd), 32'(exp_fwd));
      chk("R5 drop", 32'(ra_drp), 32'(kind >= 2));
      chk("R9 local only", 32'(ra_loc), 32'(exp_loc));
      chk("R6 lookup count", 32'(ka_n), 32'(kind == 1));
      if (kind == 1) begin
         chk("R6 lookup key", 32'(ka_key), 32'({hi, lo}));
         chk("R7 high-half key", 32'(kc_key), 32'({hi, 12'd0}));
      end
      chk("R10 vlan-only timing", 32'(b_at), 32'(exp_vl_at));
      chk("R10 vlan-only format", 32'(rb_fmt), (kind == 0) ? 32'd1 : 32'd3);
      chk("R10 vlan-only drop", 32'(rb_drp), 32'(kind != 0));
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] bad_t;
      repeat (3) @(negedge clk);
      chk("R11 reset vld", 32'(a_vld), 0);
      chk("R11 reset fmt", 32'(a_fmt), 0);
      chk("R11 reset label", 32'(a_lbl), 0);
      chk("R11 reset fwd", 32'(a_fwd), 0);
      rst_n = 1'b1;
      for (int kind = 0; kind < 4; kind++)
         for (int m = 0; m < 2; m++)
            for (int g = 0; g < 2; g++)
               for (int u = 0; u < 2; u++)
                  for (int p = 0; p < 8; p++) begin
                     case (p % 4)
                        0: bad_t = 16'h88A8;
                        1: bad_t = 16'h893A;
                        2: bad_t = 16'h0000;
                        default: bad_t = 16'h813B;
                     endcase
                     run_frame(kind, m[0], g[0], u[0], 3'(p), 1'(p ^ kind),
                               12'((p * 32'h35B + kind * 32'h111 + m * 32'h4C + g * 7) & 32'hFFF),
                               12'((p * 32'h2C7 + u * 32'h923 + kind * 5) & 32'hFFF),
                               bad_t, (p == 5));
                  end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule